// File: doc/BRIEF.md
# Predicated Vector Register Move Sequencer

This unit carries out one register move over a vector of elements. The elements sit in consecutive registers of a small register file that the unit owns. A move is described by six things: a source and a destination register number, a scalar/vector flag for each of them, an element count, and an optional predicate mask for each side.

The kind of move is not given by an opcode. It follows from the operand flags and the predicates alone, and covers splat, sparse splat, insert, extract, copy, gather, scatter and combined gather/scatter. Once started, the unit walks the element indices and writes at most one element per clock. Masked indices are skipped in the same cycle, without a write. When the move ends, the unit raises `done` for one cycle.

Before any move, a test port loads and reads back the register file. Element reads use a copy of the source range taken when the move is accepted. Because of this, moves between overlapping ranges behave as if they went through a temporary buffer.

The control is a three-state machine:
- **IDLE**: waits for `start`; test-port writes are accepted only here.
- **WALK**: performs one element pair per cycle.
- **FIN**: drives `done`.

Its transitions are:
- IDLE to WALK when `start` is sampled high.
- WALK to WALK after a move with a vector destination.
- WALK to FIN when no further source/destination pair exists, or right after a scalar destination has been written.
- FIN to IDLE unconditionally.

Top module: `vmove_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every register reads 0 through the test port.
- R2: A scalar source, a vector destination and no destination predicate write the source value into destination elements 0 to VL-1 (splat). A vector operand at register r spans registers r to r+VL-1, wrapping modulo the register count.
- R3: A scalar source with a destination predicate writes only the destination elements whose mask bit (bit i for element i) is 1. All other registers keep their values.
- R4: A scalar source with a destination predicate that has exactly one bit set, at index j, changes only the register at destination+j (insert).
- R5: A vector source with a scalar destination writes the first source element whose predicate bit is set into the destination. With no source predicate, that element is element 0 (extract).
- R6: If an extract finds no enabled source element below VL, the destination is left unchanged and `done` is still raised. Predicate bits at or above VL never enable an element.
- R7: A vector source, a vector destination and no predicates copy element i to element i for every i below VL.
- R8: With only a source predicate, the enabled source elements are packed in ascending order into destination elements 0, 1, 2 and so on (gather).
- R9: With only a destination predicate, source elements 0, 1, 2 and so on are written in order into the enabled destination elements (scatter).
- R10: With both predicates, the n-th enabled source element goes to the n-th enabled destination element. The move stops when either side runs out of enabled elements below VL.
- R11: When the source and destination ranges overlap, the result equals a copy through a temporary buffer of the source contents at start.
- R12: `done` is high for exactly one cycle. With a vector destination and k element writes, `done` is first seen after k+1 rising edges following the start edge. With a scalar destination, it is seen after one edge.
- R13: While `busy` is high, `start` and test-port writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a move (sampled in IDLE) |
| src_idx | input | RW | Source register number |
| dst_idx | input | RW | Destination register number |
| src_vec | input | 1 | 1: source is a vector, 0: scalar |
| dst_vec | input | 1 | 1: destination is a vector, 0: scalar |
| vlen | input | CW | Element count VL (1 to MAXVL) |
| src_pen | input | 1 | Source predicate present |
| src_pmask | input | MAXVL | Source predicate, bit i for element i |
| dst_pen | input | 1 | Destination predicate present |
| dst_pmask | input | MAXVL | Destination predicate, bit i for element i |
| busy | output | 1 | Move in progress (WALK or FIN) |
| done | output | 1 | One-cycle completion pulse |
| tp_we | input | 1 | Test-port write enable |
| tp_addr | input | RW | Test-port register number |
| tp_wdata | input | XLEN | Test-port write data |
| tp_rdata | output | XLEN | Test-port read data (combinational) |

## Verification
The bench goes after the edges of each index walk, and each case traps a specific fault:
- **Predicate bits beyond VL.** A finder that ignores the length would pull in a stray element.
- **Extract with no enabled element.** A design that writes anyway would clobber the scalar with element 0.
- **Gather/scatter with unequal enabled counts.** Running past the shorter side would write extra registers.
- **Forward and backward overlapping copies.** Reading the live file instead of the start-time copy would smear one value across the destination.

The cycle count of every move is checked as well, so a walker that spends cycles on masked indices, or that misses the early stop after a scalar write, is caught. Finally, a `start` pulse and a test-port write issued mid-move confirm that neither disturbs the running move.

// File: rtl/vmove_pkg.sv
package vmove_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WALK = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/vmove_regfile.sv
// Flop-based register file: one write port, all registers visible in parallel
module vmove_regfile #(
    parameter int NREGS = 32,
    parameter int XLEN  = 32,
    parameter int RW    = $clog2(NREGS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [RW-1:0]               waddr,
    input  logic [XLEN-1:0]             wdata,
    output logic [NREGS-1:0][XLEN-1:0]  regs_o
);

    logic [NREGS-1:0][XLEN-1:0] regs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (we) begin
            regs_q[waddr] <= wdata;
        end
    end

    assign regs_o = regs_q;

endmodule

// File: rtl/vmove_maskgen.sv
// Effective element mask: predicate (or all ones when absent) limited to VL
module vmove_maskgen #(
    parameter int MAXVL = 8,
    parameter int CW    = $clog2(MAXVL + 1)
) (
    input  logic              pred_en,
    input  logic [MAXVL-1:0]  pred_bits,
    input  logic [CW-1:0]     vlen,
    output logic [MAXVL-1:0]  mask
);

    for (genvar k = 0; k < MAXVL; k++) begin : g_bit
        assign mask[k] = (pred_en ? pred_bits[k] : 1'b1) && (CW'(k) < vlen);
    end

endmodule

// File: rtl/vmove_scan.sv
// Finds the lowest set mask bit at or above a starting index
module vmove_scan #(
    parameter int MAXVL = 8,
    parameter int CW    = $clog2(MAXVL + 1),
    parameter int IW    = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
    input  logic [MAXVL-1:0]  mask,
    input  logic [CW-1:0]     from,
    output logic              hit,
    output logic [IW-1:0]     pos
);

    always_comb begin
        hit = 1'b0;
        pos = '0;
        for (int k = MAXVL - 1; k >= 0; k--) begin
            if (mask[k] && (CW'(k) >= from)) begin
                hit = 1'b1;
                pos = IW'(k);
            end
        end
    end

endmodule

// File: rtl/vmove_seq.sv
module vmove_seq
    import vmove_pkg::*;
#(
    parameter int NREGS = 32,
    parameter int XLEN  = 32,
    parameter int MAXVL = 8,
    localparam int RW   = $clog2(NREGS),
    localparam int CW   = $clog2(MAXVL + 1),
    localparam int IW   = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RW-1:0]     src_idx,
    input  logic [RW-1:0]     dst_idx,
    input  logic              src_vec,
    input  logic              dst_vec,
    input  logic [CW-1:0]     vlen,
    input  logic              src_pen,
    input  logic [MAXVL-1:0]  src_pmask,
    input  logic              dst_pen,
    input  logic [MAXVL-1:0]  dst_pmask,
    output logic              busy,
    output logic              done,
    input  logic              tp_we,
    input  logic [RW-1:0]     tp_addr,
    input  logic [XLEN-1:0]   tp_wdata,
    output logic [XLEN-1:0]   tp_rdata
);

    // ---------------------------------------------------------------
    // State and latched operation
    // ---------------------------------------------------------------
    seq_state_e state_q, state_d;

    logic [RW-1:0]              dst_q;
    logic                       svec_q, dvec_q;
    logic [CW-1:0]              vl_q;
    logic [MAXVL-1:0]           smask_q, dmask_q;
    logic [CW-1:0]              si_q, di_q;
    logic [MAXVL-1:0][XLEN-1:0] snap_q;

    logic [NREGS-1:0][XLEN-1:0] rf_regs;
    logic [MAXVL-1:0]           smask_in, dmask_in;

    logic                       accept;
    logic                       s_hit, d_hit;
    logic [IW-1:0]              s_pos, d_pos;
    logic                       src_ok, dst_ok;
    logic [IW-1:0]              src_sel, dst_sel;
    logic                       step;

    logic                       eng_we;
    logic [RW-1:0]              eng_waddr;
    logic [XLEN-1:0]            eng_wdata;

    logic                       rf_we;
    logic [RW-1:0]              rf_waddr;
    logic [XLEN-1:0]            rf_wdata;

    // ---------------------------------------------------------------
    // Submodules
    // ---------------------------------------------------------------
    vmove_regfile #(.NREGS(NREGS), .XLEN(XLEN), .RW(RW)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (rf_we),
        .waddr  (rf_waddr),
        .wdata  (rf_wdata),
        .regs_o (rf_regs)
    );

    vmove_maskgen #(.MAXVL(MAXVL), .CW(CW)) u_smask (
        .pred_en   (src_pen),
        .pred_bits (src_pmask),
        .vlen      (vlen),
        .mask      (smask_in)
    );

    vmove_maskgen #(.MAXVL(MAXVL), .CW(CW)) u_dmask (
        .pred_en   (dst_pen),
        .pred_bits (dst_pmask),
        .vlen      (vlen),
        .mask      (dmask_in)
    );

    vmove_scan #(.MAXVL(MAXVL), .CW(CW), .IW(IW)) u_sscan (
        .mask (smask_q),
        .from (si_q),
        .hit  (s_hit),
        .pos  (s_pos)
    );

    vmove_scan #(.MAXVL(MAXVL), .CW(CW), .IW(IW)) u_dscan (
        .mask (dmask_q),
        .from (di_q),
        .hit  (d_hit),
        .pos  (d_pos)
    );

    // ---------------------------------------------------------------
    // Pair selection: a scalar source always offers element 0; a scalar
    // destination accepts exactly one write.
    // ---------------------------------------------------------------
    always_comb begin
        src_ok  = svec_q ? s_hit : 1'b1;
        src_sel = svec_q ? s_pos : '0;
        dst_ok  = dvec_q ? d_hit : (di_q == '0);
        dst_sel = dvec_q ? d_pos : '0;
    end

    assign accept    = (state_q == SEQ_IDLE) && start;
    assign step      = (state_q == SEQ_WALK) && src_ok && dst_ok;
    assign eng_we    = step;
    assign eng_waddr = dst_q + RW'(dst_sel);
    assign eng_wdata = snap_q[src_sel];

    // Register file write arbitration: test port only while idle
    always_comb begin
        rf_we    = eng_we || (tp_we && (state_q == SEQ_IDLE));
        rf_waddr = eng_we ? eng_waddr : tp_addr;
        rf_wdata = eng_we ? eng_wdata : tp_wdata;
    end

    assign tp_rdata = rf_regs[tp_addr];

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (start)              state_d = SEQ_WALK;
            SEQ_WALK: if (!step || !dvec_q)   state_d = SEQ_FIN;
            SEQ_FIN:                          state_d = SEQ_IDLE;
            default:                          state_d = SEQ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            SEQ_IDLE: ;
            SEQ_WALK: busy = 1'b1;
            SEQ_FIN:  begin busy = 1'b1; done = 1'b1; end
            default:  ;
        endcase
    end

    // ---------------------------------------------------------------
    // Operation capture and index walk
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst_q   <= '0;
            svec_q  <= 1'b0;
            dvec_q  <= 1'b0;
            vl_q    <= '0;
            smask_q <= '0;
            dmask_q <= '0;
            si_q    <= '0;
            di_q    <= '0;
            snap_q  <= '0;
        end else if (accept) begin
            dst_q   <= dst_idx;
            svec_q  <= src_vec;
            dvec_q  <= dst_vec;
            vl_q    <= vlen;
            smask_q <= smask_in;
            dmask_q <= dmask_in;
            si_q    <= '0;
            di_q    <= '0;
            for (int k = 0; k < MAXVL; k++) begin
                snap_q[k] <= rf_regs[src_idx + RW'(k)];
            end
        end else if (step) begin
            si_q <= CW'(src_sel) + CW'(1);
            di_q <= CW'(dst_sel) + CW'(1);
        end
    end

endmodule

// File: rtl/vmove_seq_chk.sv
module vmove_seq_chk #(
    parameter int RW = 5,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          eng_we,
    input logic [RW-1:0] eng_waddr,
    input logic [RW-1:0] dst_q,
    input logic          dvec_q,
    input logic [CW-1:0] vl_q
);

    logic [CW:0] wr_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt <= '0;
        end else if (start && !busy) begin
            wr_cnt <= '0;
        end else if (eng_we) begin
            wr_cnt <= wr_cnt + 1'b1;
        end
    end

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_write_only_walking_R13: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> (busy && !done));

    assert_write_limit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> ((wr_cnt < {1'b0, vl_q}) || !dvec_q));

    assert_scalar_dst_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && !dvec_q) |=> done);

    assert_dst_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && dvec_q) |-> ({{CW{1'b0}}, RW'(eng_waddr - dst_q)} < {{RW{1'b0}}, vl_q}));

    assert_scalar_dst_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && !dvec_q) |-> (eng_waddr == dst_q));

endmodule

bind vmove_seq vmove_seq_chk #(.RW(RW), .CW(CW)) u_vmove_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .eng_we    (eng_we),
    .eng_waddr (eng_waddr),
    .dst_q     (dst_q),
    .dvec_q    (dvec_q),
    .vl_q      (vl_q)
);

// File: tb/test_vmove_seq.sv
module test_vmove_seq;

    localparam int NREGS = 32;
    localparam int XLEN  = 32;
    localparam int MAXVL = 8;
    localparam int RW    = 5;
    localparam int CW    = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic             rst_n;
    logic             start;
    logic [RW-1:0]    src_idx, dst_idx;
    logic             src_vec, dst_vec;
    logic [CW-1:0]    vlen;
    logic             src_pen, dst_pen;
    logic [MAXVL-1:0] src_pmask, dst_pmask;
    logic             busy, done;
    logic             tp_we;
    logic [RW-1:0]    tp_addr;
    logic [XLEN-1:0]  tp_wdata, tp_rdata;

    vmove_seq #(.NREGS(NREGS), .XLEN(XLEN), .MAXVL(MAXVL)) i_vmove_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_idx(src_idx), .dst_idx(dst_idx),
        .src_vec(src_vec), .dst_vec(dst_vec), .vlen(vlen),
        .src_pen(src_pen), .src_pmask(src_pmask),
        .dst_pen(dst_pen), .dst_pmask(dst_pmask),
        .busy(busy), .done(done),
        .tp_we(tp_we), .tp_addr(tp_addr), .tp_wdata(tp_wdata), .tp_rdata(tp_rdata)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [XLEN-1:0] model [NREGS];

    task automatic check(bit ok, string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        wrap_up();
    end

    task automatic fill(int seed);
        for (int r = 0; r < NREGS; r++) begin
            @(negedge clk);
            tp_we    = 1'b1;
            tp_addr  = RW'(r);
            tp_wdata = (32'(seed) << 20) ^ 32'(r * 37 + 1);
            model[r] = tp_wdata;
        end
        @(negedge clk);
        tp_we = 1'b0;
    endtask

    task automatic check_regs(string tag);
        int bad = -1;
        logic [XLEN-1:0] act = '0;
        logic [XLEN-1:0] exp = '0;
        for (int r = 0; r < NREGS; r++) begin
            tp_addr = RW'(r);
            #1;
            if (bad < 0 && tp_rdata !== model[r]) begin
                bad = r;
                act = tp_rdata;
                exp = model[r];
            end
        end
        check(bad < 0, tag, $sformatf("register %0d", bad), act, exp);
    endtask

    // Reference model taken from the requirements; updates the mirror and
    // returns the number of element writes.
    function automatic int ref_move(int s, int d, bit sv, bit dv, int vl,
                                    bit spe, logic [7:0] sp, bit dpe, logic [7:0] dp);
        logic [XLEN-1:0] snap [MAXVL];
        bit smk [MAXVL];
        bit dmk [MAXVL];
        int si = 0, di = 0, k = 0, ns, nd;
        bit go = 1;
        for (int i = 0; i < MAXVL; i++) begin
            snap[i] = model[(s + i) % NREGS];
            smk[i]  = (i < vl) && (!spe || sp[i]);
            dmk[i]  = (i < vl) && (!dpe || dp[i]);
        end
        while (go) begin
            ns = -1;
            nd = -1;
            if (sv) begin
                for (int i = MAXVL - 1; i >= si; i--) if (smk[i]) ns = i;
            end else ns = 0;
            if (dv) begin
                for (int i = MAXVL - 1; i >= di; i--) if (dmk[i]) nd = i;
            end else nd = (di == 0) ? 0 : -1;
            if (ns < 0 || nd < 0) begin
                go = 0;
            end else begin
                model[(d + nd) % NREGS] = snap[ns];
                k++;
                si = ns + 1;
                di = nd + 1;
                if (!dv) go = 0;
            end
        end
        return k;
    endfunction

    task automatic run_op(string tag, int s, int d, bit sv, bit dv, int vl,
                          bit spe, logic [7:0] sp, bit dpe, logic [7:0] dp, bit disturb);
        int k, n, exp_n;
        k = ref_move(s, d, sv, dv, vl, spe, sp, dpe, dp);
        exp_n = dv ? k + 1 : 1;
        @(negedge clk);
        src_idx = RW'(s); dst_idx = RW'(d);
        src_vec = sv;     dst_vec = dv;   vlen = CW'(vl);
        src_pen = spe;    src_pmask = sp;
        dst_pen = dpe;    dst_pmask = dp;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            start    = 1'b1;
            src_idx  = RW'(28); dst_idx = RW'(0);
            src_vec  = 1'b0;    dst_vec = 1'b1; vlen = CW'(8);
            src_pen  = 1'b0;    dst_pen = 1'b0;
            tp_we    = 1'b1;    tp_addr = RW'(31); tp_wdata = 32'hDEAD_BEEF;
        end
        n = 0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 1) begin
                start = 1'b0;
                tp_we = 1'b0;
            end
            if (done || n > 40) break;
        end
        check(n == exp_n, "R12", {tag, " cycles to done"}, 32'(n), 32'(exp_n));
        @(negedge clk);
        check(done == 1'b0, "R12", {tag, " done pulse width"}, 32'(done), 32'd0);
        check_regs(tag);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; tp_we = 1'b0; tp_addr = '0; tp_wdata = '0;
        src_idx = '0; dst_idx = '0; src_vec = 1'b0; dst_vec = 1'b0; vlen = '0;
        src_pen = 1'b0; dst_pen = 1'b0; src_pmask = '0; dst_pmask = '0;
        for (int r = 0; r < NREGS; r++) model[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(busy == 1'b0, "R1", "busy after reset", 32'(busy), 32'd0);
        check(done == 1'b0, "R1", "done after reset", 32'(done), 32'd0);
        check_regs("R1");

        // R2: splat
        fill(1);
        run_op("R2 splat", 2, 8, 0, 1, 8, 0, 8'h00, 0, 8'h00, 0);
        // R2: splat wrapping past the last register
        run_op("R2 splat wrap", 5, 29, 0, 1, 5, 0, 8'h00, 0, 8'h00, 0);

        // R3: sparse splat
        fill(2);
        run_op("R3 sparse splat", 3, 16, 0, 1, 8, 0, 8'h00, 1, 8'b1010_0101, 0);

        // R4: insert
        fill(3);
        run_op("R4 insert", 1, 16, 0, 1, 8, 0, 8'h00, 1, 8'b0001_0000, 0);

        // R5: extract first enabled, then unpredicated extract
        fill(4);
        run_op("R5 extract", 8, 1, 1, 0, 6, 1, 8'b0011_0100, 0, 8'h00, 0);
        run_op("R5 extract elem0", 12, 2, 1, 0, 4, 0, 8'h00, 0, 8'h00, 0);

        // R6: extract with nothing enabled below VL
        fill(5);
        run_op("R6 extract none", 8, 3, 1, 0, 4, 1, 8'b1100_0000, 0, 8'h00, 0);

        // R7: plain copy
        fill(6);
        run_op("R7 copy", 8, 20, 1, 1, 5, 0, 8'h00, 0, 8'h00, 0);

        // R8: gather
        fill(7);
        run_op("R8 gather", 0, 24, 1, 1, 8, 1, 8'b1001_0110, 0, 8'h00, 0);

        // R9: scatter, mask bit 7 lies beyond VL
        fill(8);
        run_op("R9 scatter", 0, 16, 1, 1, 7, 0, 8'h00, 1, 8'b1110_1001, 0);

        // R10: gather/scatter, source side runs out first
        fill(9);
        run_op("R10 gather-scatter", 0, 16, 1, 1, 8, 1, 8'b0100_1010, 1, 8'b1011_0110, 0);
        // R10: destination side runs out first
        run_op("R10 gather-scatter dst short", 4, 20, 1, 1, 8, 1, 8'b1111_0110, 1, 8'b0001_0010, 0);

        // R11: overlapping ranges in both directions
        fill(10);
        run_op("R11 overlap up", 4, 6, 1, 1, 6, 0, 8'h00, 0, 8'h00, 0);
        run_op("R11 overlap down", 14, 12, 1, 1, 6, 0, 8'h00, 0, 8'h00, 0);

        // R13: start and test-port write during a move are ignored
        fill(11);
        run_op("R13 busy ignore", 0, 10, 1, 1, 8, 0, 8'h00, 0, 8'h00, 1);

        repeat (2) @(negedge clk);
        wrap_up();
    end

endmodule